// File: doc/BRIEF.md
# Write Completion Reply Combiner

This block sits between a processor and a directory-based coherent network. The processor sends writes to shared blocks and waits for completion. For each write the network returns two kinds of reply. One is a single exclusive grant from the home node, which says only that the write has been serialized at memory. The others are invalidation acknowledgements from the sharers, one per sharer, which show that the write is now visible to that sharer. The processor accepts exactly one reply per write. The block therefore holds each write in a tagged slot until the grant and every acknowledgement have arrived, and then returns a single one-cycle completion pulse carrying the tag. The completion is never sent on the grant alone, which keeps later accesses from becoming visible ahead of an unfinished write.

The grant carries the number of acknowledgements to expect, and zero is a legal count. Acknowledgements may arrive before the grant; the slot counts them from the moment it is opened, so early arrivals are kept. A fixed number of slots, indexed by tag, may be in flight at once. The processor chooses the tag. The write interface is valid/ready: a write is taken on a cycle where both are high, and ready is low while the slot for the presented tag is still in use, so the processor must hold its request until the slot frees. Network replies have a valid pin only and are never stalled. A reply that names an idle slot sets a sticky error flag and is otherwise dropped.

Top module: `wcm_top`

## Requirements
- R1: After reset every slot is idle, `wr_ready` is high for every tag, `done_valid` is low and `proto_err` is low. The reset is synchronous and active high.
- R2: A write is taken when `wr_valid` and `wr_ready` are both high. `wr_ready` is low for a tag whose slot is in use, from the cycle after the write is taken until the cycle after that slot's completion pulse.
- R3: A slot never completes before its grant has arrived, no matter how many acknowledgements it has already counted.
- R4: A grant with an acknowledgement count of zero to an open slot raises `done_valid` with that tag in the cycle after the grant, if no lower tag is also complete.
- R5: A slot with a grant count of N completes in the cycle after its acknowledgement count first reaches N. Acknowledgements that come before the grant count toward N, so a grant that arrives after N acknowledgements completes the slot in the next cycle.
- R6: `done_valid` is a one-cycle pulse for each write. The slot it names is freed at the end of that cycle.
- R7: When several slots are complete in the same cycle, they are reported one per cycle, lowest tag first. The others wait.
- R8: An acknowledgement to an idle slot, a grant to an idle slot, a second grant to an already granted slot, or an acknowledgement beyond `MAX_ACK` sets `proto_err`. The flag stays set until reset, and the offending reply changes no slot state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Processor presents a write |
| wr_ready | output | 1 | Slot for `wr_tag` is free; write is taken when both are high |
| wr_tag | input | TAG_W | Tag chosen by the processor for the write |
| gnt_valid | input | 1 | Exclusive grant from the home node |
| gnt_tag | input | TAG_W | Tag of the grant |
| gnt_acks | input | CNT_W | Number of invalidation acknowledgements to expect |
| inv_valid | input | 1 | Invalidation acknowledgement from a sharer |
| inv_tag | input | TAG_W | Tag of the acknowledgement |
| done_valid | output | 1 | One-cycle completion pulse to the processor |
| done_tag | output | TAG_W | Tag of the completed write |
| proto_err | output | 1 | Sticky flag for stray or excess replies |

## Verification
The hardest case to reach from the ports is two slots becoming complete on the same clock edge. The network delivers at most one grant and one acknowledgement per cycle, so the bench sets this up on purpose. It grants a higher tag a count of one, then in a single cycle sends a zero-count grant to a lower tag together with the last acknowledgement for the higher tag. This shows both the lowest-first order and the waiting slot. Early acknowledgements are covered by sending all of a slot's acknowledgements before its grant. A long randomized run, compared cycle by cycle against a behavioural model, then mixes stray replies, early acknowledgements and reuse of a tag right after it frees.

// File: rtl/wcm_pkg.sv
package wcm_pkg;

  // Life cycle of one write slot.
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,  // free, may be opened by the processor
    PH_OPEN    = 2'd1,  // write accepted, grant not yet seen
    PH_GRANTED = 2'd2   // grant seen, ack target known
  } slot_phase_t;

  localparam int DEF_NUM_TAGS = 4;
  localparam int DEF_MAX_ACK  = 7;

endpackage

// File: rtl/wcm_slot.sv
module wcm_slot
  import wcm_pkg::*;
#(
  parameter int IDX     = 0,
  parameter int TAG_W   = 2,
  parameter int CNT_W   = 3,
  parameter int MAX_ACK = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_fire,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             gnt_valid,
  input  logic [TAG_W-1:0] gnt_tag,
  input  logic [CNT_W-1:0] gnt_acks,
  input  logic             inv_valid,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic             done_valid,
  input  logic [TAG_W-1:0] done_tag,
  output logic             busy,
  output logic             granted,
  output logic             ack_full,
  output logic             complete
);

  localparam logic [TAG_W-1:0] MY_TAG  = TAG_W'(IDX);
  localparam logic [CNT_W-1:0] ACK_TOP = CNT_W'(MAX_ACK);

  slot_phase_t      phase_q;
  logic [CNT_W-1:0] need_q;
  logic [CNT_W-1:0] got_q;

  logic open_now, gnt_hit, inv_hit, free_now;

  assign busy     = (phase_q != PH_IDLE);
  assign granted  = (phase_q == PH_GRANTED);
  assign ack_full = (got_q == ACK_TOP);

  assign open_now = wr_fire && (wr_tag == MY_TAG);
  assign gnt_hit  = gnt_valid && (gnt_tag == MY_TAG) && (phase_q == PH_OPEN);
  assign inv_hit  = inv_valid && (inv_tag == MY_TAG) && busy && !ack_full;
  assign free_now = done_valid && (done_tag == MY_TAG);

  assign complete = granted && (got_q >= need_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      need_q  <= '0;
      got_q   <= '0;
    end else if (free_now) begin
      phase_q <= PH_IDLE;
      need_q  <= '0;
      got_q   <= '0;
    end else if (open_now && !busy) begin
      phase_q <= PH_OPEN;
      need_q  <= '0;
      got_q   <= '0;
    end else begin
      if (inv_hit) begin
        got_q <= got_q + CNT_W'(1);
      end
      if (gnt_hit) begin
        phase_q <= PH_GRANTED;
        need_q  <= gnt_acks;
      end
    end
  end

  AST_OPEN_TAKES: assert property (@(posedge clk) disable iff (rst)
    (open_now && !busy) |=> busy); // R2
  AST_FREE_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    (busy && !free_now) |=> busy); // R6
  AST_NO_DONE_UNGRANTED: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_OPEN) && !gnt_hit) |=> !complete); // R3
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (gnt_hit && (gnt_acks == '0) && !free_now) |=> complete); // R4

endmodule

// File: rtl/wcm_pick.sv
module wcm_pick #(
  parameter int NUM_TAGS = 4,
  parameter int TAG_W    = 2
) (
  input  logic [NUM_TAGS-1:0] ready_vec,
  output logic                any,
  output logic [TAG_W-1:0]    idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_TAGS - 1; i >= 0; i--) begin
      if (ready_vec[i]) begin
        any = 1'b1;
        idx = TAG_W'(i);
      end
    end
  end

endmodule

// File: rtl/wcm_err.sv
module wcm_err (
  input  logic clk,
  input  logic rst,
  input  logic inv_valid,
  input  logic inv_slot_busy,
  input  logic inv_slot_full,
  input  logic gnt_valid,
  input  logic gnt_slot_busy,
  input  logic gnt_slot_granted,
  output logic err
);

  logic stray_inv, stray_gnt;

  assign stray_inv = inv_valid && (!inv_slot_busy || inv_slot_full);
  assign stray_gnt = gnt_valid && (!gnt_slot_busy || gnt_slot_granted);

  always_ff @(posedge clk) begin
    if (rst) begin
      err <= 1'b0;
    end else if (stray_inv || stray_gnt) begin
      err <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(stray_inv || stray_gnt)); // R8

endmodule

// File: rtl/wcm_top.sv
module wcm_top
  import wcm_pkg::*;
#(
  parameter int NUM_TAGS = DEF_NUM_TAGS,
  parameter int MAX_ACK  = DEF_MAX_ACK,
  parameter int TAG_W    = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1,
  parameter int CNT_W    = $clog2(MAX_ACK + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             gnt_valid,
  input  logic [TAG_W-1:0] gnt_tag,
  input  logic [CNT_W-1:0] gnt_acks,
  input  logic             inv_valid,
  input  logic [TAG_W-1:0] inv_tag,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag,
  output logic             proto_err
);

  logic [NUM_TAGS-1:0] busy_vec;
  logic [NUM_TAGS-1:0] granted_vec;
  logic [NUM_TAGS-1:0] full_vec;
  logic [NUM_TAGS-1:0] cmpl_vec;
  logic                wr_fire;

  assign wr_ready = !busy_vec[wr_tag];
  assign wr_fire  = wr_valid && wr_ready;

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
    wcm_slot #(
      .IDX    (g),
      .TAG_W  (TAG_W),
      .CNT_W  (CNT_W),
      .MAX_ACK(MAX_ACK)
    ) i_slot (
      .clk       (clk),
      .rst       (rst),
      .wr_fire   (wr_fire),
      .wr_tag    (wr_tag),
      .gnt_valid (gnt_valid),
      .gnt_tag   (gnt_tag),
      .gnt_acks  (gnt_acks),
      .inv_valid (inv_valid),
      .inv_tag   (inv_tag),
      .done_valid(done_valid),
      .done_tag  (done_tag),
      .busy      (busy_vec[g]),
      .granted   (granted_vec[g]),
      .ack_full  (full_vec[g]),
      .complete  (cmpl_vec[g])
    );
  end

  wcm_pick #(
    .NUM_TAGS(NUM_TAGS),
    .TAG_W   (TAG_W)
  ) i_pick (
    .ready_vec(cmpl_vec),
    .any      (done_valid),
    .idx      (done_tag)
  );

  wcm_err i_err (
    .clk             (clk),
    .rst             (rst),
    .inv_valid       (inv_valid),
    .inv_slot_busy   (busy_vec[inv_tag]),
    .inv_slot_full   (full_vec[inv_tag]),
    .gnt_valid       (gnt_valid),
    .gnt_slot_busy   (busy_vec[gnt_tag]),
    .gnt_slot_granted(granted_vec[gnt_tag]),
    .err             (proto_err)
  );

  AST_DONE_NAMES_LIVE: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (busy_vec[done_tag] && granted_vec[done_tag])); // R6
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> (!done_valid || (done_tag != $past(done_tag)))); // R6
  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && busy_vec[wr_tag]) |-> !wr_ready); // R2
  AST_COMPLETE_ONLY_GRANTED: assert property (@(posedge clk) disable iff (rst)
    $rose(cmpl_vec != '0) |-> $past(gnt_valid || inv_valid)); // R5

endmodule

// File: tb/test_wcm_top.sv
module test_wcm_top;

  localparam int NT = 4;
  localparam int MA = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [1:0] wr_tag = '0;
  logic       gnt_valid = 1'b0;
  logic [1:0] gnt_tag = '0;
  logic [2:0] gnt_acks = '0;
  logic       inv_valid = 1'b0;
  logic [1:0] inv_tag = '0;
  logic       done_valid;
  logic [1:0] done_tag;
  logic       proto_err;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit started = 1'b0;
  string phase_req = "R1";

  // behavioural reference state
  int m_busy[NT];
  int m_gr[NT];
  int m_need[NT];
  int m_got[NT];
  bit m_err;

  always #10 clk = ~clk;

  wcm_top i_wcm_top (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_tag(wr_tag),
    .gnt_valid(gnt_valid), .gnt_tag(gnt_tag), .gnt_acks(gnt_acks),
    .inv_valid(inv_valid), .inv_tag(inv_tag),
    .done_valid(done_valid), .done_tag(done_tag), .proto_err(proto_err)
  );

  function automatic int exp_pick();
    for (int i = 0; i < NT; i++) begin
      if (m_busy[i] != 0 && m_gr[i] != 0 && m_got[i] >= m_need[i]) return i;
    end
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model update at each edge
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NT; i++) begin
        m_busy[i] = 0; m_gr[i] = 0; m_need[i] = 0; m_got[i] = 0;
      end
      m_err = 1'b0;
    end else begin
      int pk;
      int ai, gi, wi;
      bit ack_ok, gnt_ok;
      pk = exp_pick();
      ai = int'(inv_tag); gi = int'(gnt_tag); wi = int'(wr_tag);
      ack_ok = inv_valid && m_busy[ai] != 0 && m_got[ai] < MA;
      gnt_ok = gnt_valid && m_busy[gi] != 0 && m_gr[gi] == 0;
      if (inv_valid && !ack_ok) m_err = 1'b1;
      if (gnt_valid && !gnt_ok) m_err = 1'b1;
      if (ack_ok) m_got[ai]++;
      if (gnt_ok) begin m_gr[gi] = 1; m_need[gi] = int'(gnt_acks); end
      if (wr_valid && m_busy[wi] == 0) begin
        m_busy[wi] = 1; m_gr[wi] = 0; m_need[wi] = 0; m_got[wi] = 0;
      end
      if (pk >= 0) begin
        m_busy[pk] = 0; m_gr[pk] = 0; m_need[pk] = 0; m_got[pk] = 0;
      end
    end
    started = 1'b1;
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (started) begin
      int pk;
      pk = exp_pick();
      check(done_valid == (pk >= 0), phase_req, "done_valid", int'(done_valid), int'(pk >= 0));
      if (pk >= 0 && done_valid)
        check(int'(done_tag) == pk, phase_req, "done_tag", int'(done_tag), pk);
      check(proto_err == m_err, "R8", "proto_err", int'(proto_err), int'(m_err));
      check(wr_ready == (m_busy[int'(wr_tag)] == 0), "R2", "wr_ready",
            int'(wr_ready), int'(m_busy[int'(wr_tag)] == 0));
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
    wr_valid = 1'b0; gnt_valid = 1'b0; inv_valid = 1'b0;
  endtask

  task automatic peek_done(input string req, input bit ev, input int et);
    #5;
    check(done_valid == ev, req, "done_valid (directed)", int'(done_valid), int'(ev));
    if (ev) check(int'(done_tag) == et, req, "done_tag (directed)", int'(done_tag), et);
  endtask

  task automatic open_slot(input int t);
    wr_valid = 1'b1; wr_tag = 2'(t);
    tick();
  endtask

  task automatic send_gnt(input int t, input int n);
    gnt_valid = 1'b1; gnt_tag = 2'(t); gnt_acks = 3'(n);
    tick();
  endtask

  task automatic send_ack(input int t);
    inv_valid = 1'b1; inv_tag = 2'(t);
    tick();
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #2; rst = 1'b0;
    #5;
    // R1 reset state
    check(done_valid == 1'b0, "R1", "done_valid after reset", int'(done_valid), 0);
    check(proto_err == 1'b0, "R1", "proto_err after reset", int'(proto_err), 0);
    for (int t = 0; t < NT; t++) begin
      wr_tag = 2'(t); #1;
      check(wr_ready == 1'b1, "R1", "wr_ready after reset", int'(wr_ready), 1);
    end

    // R4 zero-count grant
    phase_req = "R4";
    open_slot(0);
    #5 check(wr_ready == 1'b0, "R2", "ready low on busy tag", int'(wr_ready), 0);
    send_gnt(0, 0);
    peek_done("R4", 1'b1, 0);
    tick();
    peek_done("R6", 1'b0, 0);
    wr_tag = 2'd0; #1;
    check(wr_ready == 1'b1, "R6", "slot freed after done", int'(wr_ready), 1);

    // R5 grant first, then acks
    phase_req = "R5";
    open_slot(1);
    send_gnt(1, 3);
    peek_done("R3", 1'b0, 0);
    send_ack(1);
    send_ack(1);
    peek_done("R5", 1'b0, 0);
    send_ack(1);
    peek_done("R5", 1'b1, 1);
    tick();

    // R3 / R5 acks before grant
    phase_req = "R3";
    open_slot(2);
    send_ack(2);
    send_ack(2);
    peek_done("R3", 1'b0, 0);
    tick();
    peek_done("R3", 1'b0, 0);
    phase_req = "R5";
    send_gnt(2, 2);
    peek_done("R5", 1'b1, 2);
    tick();

    // R2 held request on busy slot waits
    phase_req = "R2";
    open_slot(3);
    wr_valid = 1'b1; wr_tag = 2'd3;
    #5 check(wr_ready == 1'b0, "R2", "held write stalled", int'(wr_ready), 0);
    tick();
    send_gnt(3, 0);
    tick();

    // R7 two completions on one edge
    phase_req = "R7";
    open_slot(1);
    open_slot(3);
    send_gnt(3, 1);
    gnt_valid = 1'b1; gnt_tag = 2'd1; gnt_acks = 3'd0;
    inv_valid = 1'b1; inv_tag = 2'd3;
    tick();
    peek_done("R7", 1'b1, 1);
    tick();
    peek_done("R7", 1'b1, 3);
    tick();
    peek_done("R7", 1'b0, 0);

    // R8 stray replies
    phase_req = "R8";
    #5 check(proto_err == 1'b0, "R8", "no error yet", int'(proto_err), 0);
    send_ack(2);
    #5 check(proto_err == 1'b1, "R8", "stray ack flagged", int'(proto_err), 1);
    open_slot(0);
    send_gnt(0, 1);
    send_gnt(0, 0);
    peek_done("R8", 1'b0, 0);
    send_ack(0);
    peek_done("R8", 1'b1, 0);
    tick();
    #5 check(proto_err == 1'b1, "R8", "error sticky", int'(proto_err), 1);

    // R1 mid-run reset clears the flag
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    #5 check(proto_err == 1'b0, "R1", "flag cleared by reset", int'(proto_err), 0);

    // randomized traffic against the model
    phase_req = "R5";
    for (int k = 0; k < 4000; k++) begin
      wr_valid  = ($urandom_range(0, 2) == 0);
      wr_tag    = 2'($urandom_range(0, NT - 1));
      gnt_valid = ($urandom_range(0, 3) == 0);
      gnt_tag   = 2'($urandom_range(0, NT - 1));
      gnt_acks  = 3'($urandom_range(0, 3));
      inv_valid = ($urandom_range(0, 1) == 0);
      inv_tag   = 2'($urandom_range(0, NT - 1));
      if (k == 2000) begin
        rst = 1'b1;
      end else begin
        rst = 1'b0;
      end
      tick();
    end
    rst = 1'b0;
    tick(); tick();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule